// File: doc/BRIEF.md
# Reverse-Direction Parallel Port Byte Receiver (Host Side)

This block is the host end of the interlocked handshake a peripheral uses to send bytes back to the host over a parallel cable. The peripheral drives eight data lines, a data/command tag line and an active-low strobe. The host answers on a single acknowledge line. Each byte the peripheral offers is captured together with its tag and written into a receive FIFO as a 9-bit word. The FIFO sits outside this block; the block only drives the FIFO's write port.

The strobe is asynchronous, so it passes through a synchronizer before the block acts on it. The block waits for a synchronized falling edge of the strobe and then samples the data and tag lines, which are stable by then. It writes the word into the FIFO once the FIFO has room, and only then raises the acknowledge. It drops the acknowledge when the strobe returns high, which completes the byte.

While the FIFO reports full, the acknowledge stays low, and this holds the peripheral off. If the strobe does not return high within a bounded number of clock cycles after the acknowledge rises, the block records an error. It then drops the acknowledge and goes back to idle. It accepts no further byte until the strobe has gone high and fallen again.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, `host_ack`, `fifo_wr`, `busy` and `timeout_err` are all low.
- R2: After a falling edge of `peer_strobe_n`, exactly one FIFO write occurs. The written word has `cable_data` in bits 7:0 and `peer_tag` in bit 8, where a high tag marks a command. Both are sampled while the strobe is low and before `host_ack` rises.
- R3: `host_ack` rises in the cycle after the FIFO write for that byte and never without such a write. No write occurs while `host_ack` is high.
- R4: While `fifo_full` is high, `fifo_wr` stays low and `host_ack` is not raised. The pending byte is written once `fifo_full` falls.
- R5: After `peer_strobe_n` returns high, `host_ack` returns low and `busy` falls, which completes the transfer.
- R6: If `peer_strobe_n` stays low for `TIMEOUT` cycles after `host_ack` rises, `host_ack` falls, `busy` falls and `timeout_err` goes high. Before that limit, `host_ack` stays high.
- R7: After a timeout, a strobe that is still low is not taken as a new byte. A new byte starts only after the strobe rises and falls again.
- R8: `timeout_err` stays high until the next FIFO write, which clears it.
- R9: While `peer_strobe_n` stays high, changes on `cable_data` and `peer_tag` cause no write and leave `host_ack` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cable_data | input | DW | Data lines driven by the peripheral |
| peer_tag | input | 1 | Data/command tag from the peripheral (1 = command) |
| peer_strobe_n | input | 1 | Active-low byte strobe from the peripheral (asynchronous) |
| fifo_full | input | 1 | Receive FIFO cannot take a word |
| host_ack | output | 1 | Acknowledge to the peripheral |
| fifo_wr | output | 1 | FIFO write enable, one cycle per byte |
| fifo_wdata | output | DW+1 | FIFO word: tag in the top bit, data below |
| busy | output | 1 | A transfer is in progress |
| timeout_err | output | 1 | Strobe-return timeout seen since the last write |

## Verification
The bench changes the data lines as soon as the acknowledge rises. A receiver that sampled late, rather than while the strobe was low, would store the garbage value. The bench holds the FIFO full across a strobe and checks that nothing is written and no acknowledge appears; a design that ignored back-pressure would overwrite a full FIFO. The bench also keeps the strobe low past the timeout and then keeps it low for a while longer. A design that trusted the level instead of the edge would write the same byte twice, and a design with the wrong limit would drop the acknowledge early or never. Finally, the bench checks that the error flag survives until the next good byte and is cleared by it.

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cable_data,
  input  logic          peer_tag,
  input  logic          peer_strobe_n,
  input  logic          fifo_full,
  output logic          host_ack,
  output logic          fifo_wr,
  output logic [DW:0]   fifo_wdata,
  output logic          busy,
  output logic          timeout_err
);

  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_ACK} st_t;

  st_t                st;
  logic [SYNC_STAGES:0] sh;
  logic [DW:0]        cap;
  logic [CW-1:0]      cnt;

  wire strobe_now  = sh[SYNC_STAGES-1];
  wire strobe_fall = sh[SYNC_STAGES] & ~strobe_now;

  assign fifo_wr    = (st == S_STORE) && !fifo_full;
  assign fifo_wdata = cap;
  assign host_ack   = (st == S_ACK);
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      sh          <= '1;
      cap         <= '0;
      cnt         <= '0;
      timeout_err <= 1'b0;
    end else begin
      sh <= {sh[SYNC_STAGES-1:0], peer_strobe_n};
      case (st)
        S_IDLE:
          if (strobe_fall) begin
            cap <= {peer_tag, cable_data};
            st  <= S_STORE;
          end
        S_STORE:
          if (!fifo_full) begin
            cnt <= '0;
            st  <= S_ACK;
          end
        S_ACK:
          if (strobe_now) begin
            st <= S_IDLE;
          end else if (cnt == LIMIT) begin
            st          <= S_IDLE;
            timeout_err <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
      if (fifo_wr) timeout_err <= 1'b0;
    end
  end

endmodule

module ecp_rev_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic host_ack,
  input logic fifo_wr,
  input logic fifo_full,
  input logic busy,
  input logic timeout_err
);

  // R3
  write_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> host_ack);

  // R3
  ack_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ack) |-> $past(fifo_wr));

  // R3
  no_write_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> !fifo_wr);

  // R4
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);

  // R6
  timeout_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!host_ack && !busy && $past(host_ack)));

  // R8
  write_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !timeout_err);

endmodule

bind ecp_rev_rx ecp_rev_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_ack(host_ack), .fifo_wr(fifo_wr),
  .fifo_full(fifo_full), .busy(busy), .timeout_err(timeout_err)
);

// File: tb/ecp_rev_rx_bench.sv
module ecp_rev_rx_bench;
  localparam int TMO = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cable_data = 8'h00;
  logic       peer_tag = 1'b0;
  logic       peer_strobe_n = 1'b1;
  logic       fifo_full = 1'b0;
  logic       host_ack, fifo_wr, busy, timeout_err;
  logic [8:0] fifo_wdata;

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  logic [8:0] last_word = '0;

  always #5 clk = ~clk;

  ecp_rev_rx #(.DW(8), .SYNC_STAGES(2), .TIMEOUT(TMO)) u_ecp_rev_rx (
    .clk(clk), .rst_n(rst_n), .cable_data(cable_data), .peer_tag(peer_tag),
    .peer_strobe_n(peer_strobe_n), .fifo_full(fifo_full), .host_ack(host_ack),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .busy(busy),
    .timeout_err(timeout_err)
  );

  always @(posedge clk) if (rst_n && fifo_wr) begin
    wr_cnt    <= wr_cnt + 1;
    last_word <= fifo_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input logic val, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (host_ack === val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic t);
    bit ok;
    int w0;
    w0 = wr_cnt;
    cable_data = d; peer_tag = t;
    repeat (2) @(negedge clk);
    peer_strobe_n = 1'b0;
    wait_ack(1'b1, 40, ok);
    chk(ok, "R3 ack raised", host_ack, 1);
    chk(wr_cnt == w0 + 1, "R2 one write", wr_cnt - w0, 1);
    chk(last_word == {t, d}, "R2 word", last_word, {t, d});
    cable_data = ~d; peer_tag = ~t;
    @(negedge clk);
    peer_strobe_n = 1'b1;
    wait_ack(1'b0, 40, ok);
    chk(ok, "R5 ack dropped", host_ack, 0);
    @(negedge clk);
    chk(!busy && wr_cnt == w0 + 1, "R5 idle after byte", busy, 0);
  endtask

  task automatic t_reset;
    chk(!host_ack && !fifo_wr && !busy && !timeout_err, "R1 reset",
        {host_ack, fifo_wr, busy, timeout_err}, 0);
  endtask

  task automatic t_bytes;
    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b1);
    send_byte(8'hFF, 1'b1);
    send_byte(8'h00, 1'b0);
  endtask

  task automatic t_idle;
    int w0;
    w0 = wr_cnt;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cable_data = 8'(i * 7); peer_tag = i[0];
    end
    chk(wr_cnt == w0 && !host_ack, "R9 idle ignores data", wr_cnt - w0, 0);
  endtask

  task automatic t_full;
    bit ok;
    int w0;
    w0 = wr_cnt;
    fifo_full = 1'b1;
    cable_data = 8'h96; peer_tag = 1'b1;
    repeat (2) @(negedge clk);
    peer_strobe_n = 1'b0;
    repeat (30) @(negedge clk);
    chk(wr_cnt == w0, "R4 no write while full", wr_cnt - w0, 0);
    chk(!host_ack, "R4 ack held low", host_ack, 0);
    fifo_full = 1'b0;
    wait_ack(1'b1, 10, ok);
    chk(ok && wr_cnt == w0 + 1, "R4 write after full clears", wr_cnt - w0, 1);
    chk(last_word == 9'h196, "R4 held word", last_word, 9'h196);
    peer_strobe_n = 1'b1;
    wait_ack(1'b0, 40, ok);
    chk(ok, "R5 ack dropped after stall", host_ack, 0);
  endtask

  task automatic t_timeout;
    bit ok;
    int w0;
    cable_data = 8'h5A; peer_tag = 1'b0;
    repeat (2) @(negedge clk);
    peer_strobe_n = 1'b0;
    wait_ack(1'b1, 40, ok);
    w0 = wr_cnt;
    repeat (20) @(negedge clk);
    chk(host_ack && !timeout_err, "R6 ack held before limit", host_ack, 1);
    repeat (TMO + 10) @(negedge clk);
    chk(!host_ack && !busy, "R6 ack dropped on timeout", host_ack, 0);
    chk(timeout_err, "R6 error set", timeout_err, 1);
    repeat (30) @(negedge clk);
    chk(wr_cnt == w0 && !host_ack, "R7 no duplicate byte", wr_cnt - w0, 0);
    peer_strobe_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(timeout_err && wr_cnt == w0, "R8 error kept until write", timeout_err, 1);
    send_byte(8'hC3, 1'b1);
    chk(!timeout_err, "R8 error cleared by write", timeout_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bytes();
    t_idle();
    t_full();
    t_timeout();
    t_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule